// File: doc/BRIEF.md
# Pipeline Run-Stop-Halt Controller

This block sequences a five-stage in-order integer pipeline. It tracks the run status of the processor and decides, on every accepted step, what each stage slot holds: nothing, a bubble, or a live instruction. It keeps the fetch address, the previous fetch address and a set of saturating statistics counters. The datapath, the register file and memory live elsewhere. They watch the tags and strobes this block produces, and they report decoded halts, taken jumps, hazards and floating-point activity back to it.

A program is loaded and the controller starts running. Each `step_i` pulse advances the pipeline by one cycle. When a halt reaches decode, fetching stops and the pipeline drains. The controller halts only when the integer stages and the side floating-point pipeline are both empty. While floating-point work is still in flight, a terminating instruction in write-back has its write-back withheld.

Top module: `pipe_seq_ctrl`

## Requirements
- R1: After reset, the status is idle (`status_o`=0). All five slot tags are empty (0), the fetch and previous addresses are 0, `step_err_o` is 0 and every counter is 0.
- R2: The status encoding is 0 idle, 1 running, 2 draining and 3 halted. `load_i` moves idle to running and is ignored in any other status. A step taken while the status is neither running nor draining sets `step_err_o` in the next cycle and changes no slot, address or counter.
- R3: An ordinary running step does the following. It fetches from `pc_o` with `fetch_en_o` high and advances the address by 4, saving the old value in `prev_pc_o`. It tags the fetch slot live (2). It shifts the tags forward one stage and adds 1 to the cycle counter.
- R4: A halt decode takes effect when decode holds a live instruction and no stall is active. In that case the status becomes draining and the halt moves on to execute. The decode slot then gets a bubble (1) on every step, the fetch slot is left as it was, and nothing more is fetched.
- R5: In draining, a step halts the controller (status 3, `halted_o` high) when the following all hold: write-back is not empty, decode, execute and memory hold no live instruction, and `fp_empty_i` is high. Halted persists until reset.
- R6: `wb_commit_o` is high on a step whose write-back slot is live. It is withheld when `term_wb_i` is high and either `fp_empty_i` is low or the memory slot is live.
- R7: A taken jump does the following. It fetches from `jump_tgt_i`, sets `prev_pc_o` to the target and `pc_o` to target+4, modulo the address width. It moves the old decode tag to execute and puts a bubble in decode. When a halt decode arrives in the same step, the halt wins.
- R8: Hazard codes are 1 RAW, 2 WAW, 3 divider busy and 4 FP unit busy. When decode is live, any of these puts a bubble in execute, holds the fetch and decode tags and the address, and adds 1 to its own counter. If decode is not live, the code is ignored.
- R9: Hazard code 5 (execute busy) adds 1 to its own counter, leaves execute empty, and holds the fetch and decode tags and the address.
- R10: The retired counter adds 1 on every accepted step whose write-back slot is live.
- R11: Every counter stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Program loaded; starts running from idle |
| step_i | input | 1 | Advance the pipeline one cycle |
| halt_dec_i | input | 1 | Decode slot holds a halt |
| jump_i | input | 1 | Decode slot holds a taken jump |
| jump_tgt_i | input | PC_W | Jump target address |
| hazard_i | input | 3 | Stall request code from decode |
| fp_empty_i | input | 1 | Floating-point pipeline holds no work |
| term_wb_i | input | 1 | Write-back slot holds a terminating instruction |
| status_o | output | 2 | Run status |
| halted_o | output | 1 | Status is halted |
| step_err_o | output | 1 | Previous step was rejected |
| fetch_en_o | output | 1 | Fetch this step |
| fetch_pc_o | output | PC_W | Address to fetch from |
| pc_sel_o | output | 1 | Fetch address comes from the jump target |
| pc_o | output | PC_W | Next sequential fetch address |
| prev_pc_o | output | PC_W | Address of the last fetch |
| id_bubble_o | output | 1 | Bubble placed in decode this step |
| ex_bubble_o | output | 1 | Bubble placed in execute this step |
| wb_commit_o | output | 1 | Perform write-back this step |
| if_tag_o | output | 2 | Fetch slot tag |
| id_tag_o | output | 2 | Decode slot tag |
| ex_tag_o | output | 2 | Execute slot tag |
| mem_tag_o | output | 2 | Memory slot tag |
| wb_tag_o | output | 2 | Write-back slot tag |
| cnt_cycle_o | output | CNT_W | Accepted steps |
| cnt_retire_o | output | CNT_W | Live instructions that reached write-back |
| cnt_raw_o | output | CNT_W | RAW stalls |
| cnt_waw_o | output | CNT_W | WAW stalls |
| cnt_div_o | output | CNT_W | Divider-busy stalls |
| cnt_fpu_o | output | CNT_W | FP-unit-busy stalls |
| cnt_exb_o | output | CNT_W | Execute-busy stalls |

## Verification
The bench builds the block with CNT_W=4 and PC_W=16. With 4-bit counters, the cycle and RAW counters reach their all-ones ceiling within a few dozen steps, so saturation is exercised directly. With a 16-bit address, a jump near the top of the space shows the wrap of target+4. The same run covers draining with the floating-point side busy, the halt-over-jump priority, and a hazard arriving while decode holds only a bubble.

// File: rtl/pseq_pkg.sv
// Shared encodings for the pipeline run/stop/halt controller.
// Assumes slot tags and status values are visible at the ports as raw codes.
package pseq_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_BUBBLE = 2'd1,
        SLOT_LIVE   = 2'd2
    } slot_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_RUN   = 2'd1,
        RS_DRAIN = 2'd2,
        RS_HALT  = 2'd3
    } run_t;

    typedef enum logic [2:0] {
        HZ_NONE = 3'd0,
        HZ_RAW  = 3'd1,
        HZ_WAW  = 3'd2,
        HZ_DIV  = 3'd3,
        HZ_FPU  = 3'd4,
        HZ_EXB  = 3'd5
    } hz_t;

    localparam int NUM_STG = 5;
    localparam int S_IF  = 0;
    localparam int S_ID  = 1;
    localparam int S_EX  = 2;
    localparam int S_MEM = 3;
    localparam int S_WB  = 4;

    localparam int NUM_CNT = 7;
    localparam int C_CYC = 0;
    localparam int C_RET = 1;
    // counters 2..6 follow the hazard code order: index = code + 1
    localparam int C_HZ0 = 1;
endpackage

// File: rtl/pseq_satcnt.sv
// Saturating up-counter. Adds one when inc_i is high, holds at all-ones.
// Assumes inc_i is a single-cycle event per increment.
module pseq_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // count up, stop at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)                   q_o <= '0;
        else if (inc_i && q_o != TOP) q_o <= q_o + W'(1);
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && q_o == TOP) |=> (q_o == TOP));
endmodule

// File: rtl/pseq_status.sv
// Run-status machine: idle -> running -> draining -> halted.
// Assumes halt_take_i only pulses while running and drain_done_i only while draining.
module pseq_status
    import pseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    input  logic halt_take_i,
    input  logic drain_done_i,
    output run_t status_o,
    output logic step_ok_o,
    output logic step_err_o
);
    // a step is legal only while running or draining
    always_comb step_ok_o = step_i && (status_o == RS_RUN || status_o == RS_DRAIN);

    // status transitions and rejected-step flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o   <= RS_IDLE;
            step_err_o <= 1'b0;
        end else begin
            step_err_o <= step_i && !step_ok_o;
            unique case (status_o)
                RS_IDLE:  if (load_i)       status_o <= RS_RUN;
                RS_RUN:   if (halt_take_i)  status_o <= RS_DRAIN;
                RS_DRAIN: if (drain_done_i) status_o <= RS_HALT;
                default:                    status_o <= RS_HALT;
            endcase
        end
    end

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == RS_HALT) |=> (status_o == RS_HALT));
    // R2
    step_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && status_o != RS_RUN && status_o != RS_DRAIN) |=> step_err_o);
endmodule

// File: rtl/pseq_slots.sv
// Stage-slot sequencer and fetch address keeper. All next-slot values are
// derived from the current contents, then committed on one edge.
// Assumes hazard and halt/jump inputs describe the decode slot of this cycle.
module pseq_slots
    import pseq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_ok_i,
    input  run_t                    status_i,
    input  logic                    halt_dec_i,
    input  logic                    jump_i,
    input  logic [PC_W-1:0]         jump_tgt_i,
    input  hz_t                     hz_i,
    input  logic                    fp_empty_i,
    input  logic                    term_wb_i,
    output logic [NUM_STG-1:0][1:0] tags_o,
    output logic [PC_W-1:0]         pc_o,
    output logic [PC_W-1:0]         prev_pc_o,
    output logic                    fetch_en_o,
    output logic [PC_W-1:0]         fetch_pc_o,
    output logic                    pc_sel_o,
    output logic                    id_bubble_o,
    output logic                    ex_bubble_o,
    output logic                    wb_commit_o,
    output logic                    halt_take_o,
    output logic                    drain_done_o,
    output logic [NUM_CNT-1:0]      inc_o
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    slot_t slot_q [NUM_STG];
    slot_t slot_d [NUM_STG];
    logic  stall_act, jump_take;

    // decide this step's events from current slot contents
    always_comb begin
        stall_act    = step_ok_i && hz_i != HZ_NONE && slot_q[S_ID] == SLOT_LIVE;
        halt_take_o  = step_ok_i && status_i == RS_RUN && halt_dec_i
                       && slot_q[S_ID] == SLOT_LIVE && !stall_act;
        jump_take    = step_ok_i && status_i == RS_RUN && jump_i && !halt_dec_i
                       && slot_q[S_ID] == SLOT_LIVE && !stall_act;
        fetch_en_o   = step_ok_i && status_i == RS_RUN && !halt_take_o && !stall_act;
        pc_sel_o     = jump_take;
        fetch_pc_o   = jump_take ? jump_tgt_i : pc_o;
        drain_done_o = step_ok_i && status_i == RS_DRAIN && fp_empty_i
                       && slot_q[S_WB]  != SLOT_EMPTY
                       && slot_q[S_ID]  != SLOT_LIVE
                       && slot_q[S_EX]  != SLOT_LIVE
                       && slot_q[S_MEM] != SLOT_LIVE;
        wb_commit_o  = step_ok_i && slot_q[S_WB] == SLOT_LIVE
                       && !(term_wb_i && (!fp_empty_i || slot_q[S_MEM] == SLOT_LIVE));
        ex_bubble_o  = stall_act && hz_i != HZ_EXB;
        id_bubble_o  = step_ok_i && !stall_act && (jump_take || !fetch_en_o);
    end

    // statistics increment strobes
    always_comb begin
        inc_o        = '0;
        inc_o[C_CYC] = step_ok_i;
        inc_o[C_RET] = step_ok_i && slot_q[S_WB] == SLOT_LIVE;
        for (int k = 1; k < NUM_CNT - C_HZ0; k++)
            inc_o[C_HZ0 + k] = stall_act && hz_i == hz_t'(k);
    end

    // next slot contents
    always_comb begin
        for (int s = 0; s < NUM_STG; s++) slot_d[s] = slot_q[s];
        if (step_ok_i) begin
            slot_d[S_WB]  = slot_q[S_MEM];
            slot_d[S_MEM] = slot_q[S_EX];
            if (stall_act) begin
                slot_d[S_EX] = (hz_i == HZ_EXB) ? SLOT_EMPTY : SLOT_BUBBLE;
            end else begin
                slot_d[S_EX] = slot_q[S_ID];
                if (fetch_en_o) begin
                    slot_d[S_ID] = jump_take ? SLOT_BUBBLE : slot_q[S_IF];
                    slot_d[S_IF] = SLOT_LIVE;
                end else begin
                    slot_d[S_ID] = SLOT_BUBBLE;
                end
            end
        end
    end

    // commit slots and fetch addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STG; s++) slot_q[s] <= SLOT_EMPTY;
            pc_o      <= '0;
            prev_pc_o <= '0;
        end else begin
            for (int s = 0; s < NUM_STG; s++) slot_q[s] <= slot_d[s];
            if (fetch_en_o) begin
                prev_pc_o <= fetch_pc_o;
                pc_o      <= fetch_pc_o + PC_STEP;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_STG; g++) begin : g_tag
            assign tags_o[g] = slot_q[g];
        end
    endgenerate

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_act |=> (slot_q[S_ID] == $past(slot_q[S_ID]) && pc_o == $past(pc_o)));
    // R7
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_take |=> (slot_q[S_ID] == SLOT_BUBBLE && prev_pc_o == $past(jump_tgt_i)));
    // R4
    fetch_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en_o |-> (status_i == RS_RUN));
    // R4
    drain_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok_i && status_i == RS_DRAIN) |=> (slot_q[S_ID] == SLOT_BUBBLE));
endmodule

// File: rtl/pipe_seq_ctrl.sv
// Top of the pipeline run/stop/halt controller: status machine, slot
// sequencer and a bank of saturating statistics counters.
// Assumes step_i is the only thing that advances the pipeline.
module pipe_seq_ctrl
    import pseq_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             halt_dec_i,
    input  logic             jump_i,
    input  logic [PC_W-1:0]  jump_tgt_i,
    input  logic [2:0]       hazard_i,
    input  logic             fp_empty_i,
    input  logic             term_wb_i,
    output logic [1:0]       status_o,
    output logic             halted_o,
    output logic             step_err_o,
    output logic             fetch_en_o,
    output logic [PC_W-1:0]  fetch_pc_o,
    output logic             pc_sel_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  prev_pc_o,
    output logic             id_bubble_o,
    output logic             ex_bubble_o,
    output logic             wb_commit_o,
    output logic [1:0]       if_tag_o,
    output logic [1:0]       id_tag_o,
    output logic [1:0]       ex_tag_o,
    output logic [1:0]       mem_tag_o,
    output logic [1:0]       wb_tag_o,
    output logic [CNT_W-1:0] cnt_cycle_o,
    output logic [CNT_W-1:0] cnt_retire_o,
    output logic [CNT_W-1:0] cnt_raw_o,
    output logic [CNT_W-1:0] cnt_waw_o,
    output logic [CNT_W-1:0] cnt_div_o,
    output logic [CNT_W-1:0] cnt_fpu_o,
    output logic [CNT_W-1:0] cnt_exb_o
);
    run_t                          status;
    logic                          step_ok, halt_take, drain_done;
    logic [NUM_STG-1:0][1:0]       tags;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

    pseq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .step_i       (step_i),
        .halt_take_i  (halt_take),
        .drain_done_i (drain_done),
        .status_o     (status),
        .step_ok_o    (step_ok),
        .step_err_o   (step_err_o)
    );

    pseq_slots #(.PC_W(PC_W)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_ok_i    (step_ok),
        .status_i     (status),
        .halt_dec_i   (halt_dec_i),
        .jump_i       (jump_i),
        .jump_tgt_i   (jump_tgt_i),
        .hz_i         (hz_t'(hazard_i)),
        .fp_empty_i   (fp_empty_i),
        .term_wb_i    (term_wb_i),
        .tags_o       (tags),
        .pc_o         (pc_o),
        .prev_pc_o    (prev_pc_o),
        .fetch_en_o   (fetch_en_o),
        .fetch_pc_o   (fetch_pc_o),
        .pc_sel_o     (pc_sel_o),
        .id_bubble_o  (id_bubble_o),
        .ex_bubble_o  (ex_bubble_o),
        .wb_commit_o  (wb_commit_o),
        .halt_take_o  (halt_take),
        .drain_done_o (drain_done),
        .inc_o        (inc)
    );

    generate
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            pseq_satcnt #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc_i (inc[c]),
                .q_o   (cnt[c])
            );
        end
    endgenerate

    // port mapping of status, tags and counters
    always_comb begin
        status_o     = status;
        halted_o     = (status == RS_HALT);
        if_tag_o     = tags[S_IF];
        id_tag_o     = tags[S_ID];
        ex_tag_o     = tags[S_EX];
        mem_tag_o    = tags[S_MEM];
        wb_tag_o     = tags[S_WB];
        cnt_cycle_o  = cnt[C_CYC];
        cnt_retire_o = cnt[C_RET];
        cnt_raw_o    = cnt[C_HZ0 + 1];
        cnt_waw_o    = cnt[C_HZ0 + 2];
        cnt_div_o    = cnt[C_HZ0 + 3];
        cnt_fpu_o    = cnt[C_HZ0 + 4];
        cnt_exb_o    = cnt[C_HZ0 + 5];
    end

    // R5
    drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == RS_DRAIN && !fp_empty_i) |=> (status != RS_HALT));
endmodule

// File: tb/pipe_seq_ctrl_tb.sv
`timescale 1ns/1ps
// Cycle-by-cycle behavioural model compared against the controller.
module pipe_seq_ctrl_tb_top;
    localparam int CW = 4;
    localparam int PW = 16;
    localparam int CMAX = (1 << CW) - 1;
    localparam int PMASK = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          load_i = 0, step_i = 0, halt_dec_i = 0, jump_i = 0;
    logic          fp_empty_i = 1, term_wb_i = 0;
    logic [PW-1:0] jump_tgt_i = '0;
    logic [2:0]    hazard_i = '0;

    logic [1:0]    status_o, if_tag_o, id_tag_o, ex_tag_o, mem_tag_o, wb_tag_o;
    logic          halted_o, step_err_o, fetch_en_o, pc_sel_o;
    logic          id_bubble_o, ex_bubble_o, wb_commit_o;
    logic [PW-1:0] fetch_pc_o, pc_o, prev_pc_o;
    logic [CW-1:0] cnt_cycle_o, cnt_retire_o, cnt_raw_o, cnt_waw_o;
    logic [CW-1:0] cnt_div_o, cnt_fpu_o, cnt_exb_o;

    pipe_seq_ctrl #(.PC_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .halt_dec_i(halt_dec_i), .jump_i(jump_i), .jump_tgt_i(jump_tgt_i),
        .hazard_i(hazard_i), .fp_empty_i(fp_empty_i), .term_wb_i(term_wb_i),
        .status_o(status_o), .halted_o(halted_o), .step_err_o(step_err_o),
        .fetch_en_o(fetch_en_o), .fetch_pc_o(fetch_pc_o), .pc_sel_o(pc_sel_o),
        .pc_o(pc_o), .prev_pc_o(prev_pc_o), .id_bubble_o(id_bubble_o),
        .ex_bubble_o(ex_bubble_o), .wb_commit_o(wb_commit_o),
        .if_tag_o(if_tag_o), .id_tag_o(id_tag_o), .ex_tag_o(ex_tag_o),
        .mem_tag_o(mem_tag_o), .wb_tag_o(wb_tag_o),
        .cnt_cycle_o(cnt_cycle_o), .cnt_retire_o(cnt_retire_o),
        .cnt_raw_o(cnt_raw_o), .cnt_waw_o(cnt_waw_o), .cnt_div_o(cnt_div_o),
        .cnt_fpu_o(cnt_fpu_o), .cnt_exb_o(cnt_exb_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // model state: status, slots (0 fetch .. 4 write-back), addresses, counters
    int m_st, m_pc, m_ppc, m_err;
    int m_sl [5];
    int m_cnt [7];   // cycle, retire, raw, waw, div, fpu, exbusy
    int q_fetch, q_faddr, q_commit, q_exb;

    function automatic int bump(int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_pc = 0; m_ppc = 0; m_err = 0;
        foreach (m_sl[i]) m_sl[i] = 0;
        foreach (m_cnt[i]) m_cnt[i] = 0;
    endtask

    task automatic cmp_regs(string tag);
        chk(tag, "status", int'(status_o), m_st);
        chk(tag, "halted", int'(halted_o), (m_st == 3) ? 1 : 0);
        chk(tag, "step_err", int'(step_err_o), m_err);
        chk(tag, "tag_if", int'(if_tag_o), m_sl[0]);
        chk(tag, "tag_id", int'(id_tag_o), m_sl[1]);
        chk(tag, "tag_ex", int'(ex_tag_o), m_sl[2]);
        chk(tag, "tag_mem", int'(mem_tag_o), m_sl[3]);
        chk(tag, "tag_wb", int'(wb_tag_o), m_sl[4]);
        chk(tag, "pc", int'(pc_o), m_pc);
        chk(tag, "prev_pc", int'(prev_pc_o), m_ppc);
        chk(tag, "cnt_cycle", int'(cnt_cycle_o), m_cnt[0]);
        chk(tag, "cnt_retire", int'(cnt_retire_o), m_cnt[1]);
        chk(tag, "cnt_raw", int'(cnt_raw_o), m_cnt[2]);
        chk(tag, "cnt_waw", int'(cnt_waw_o), m_cnt[3]);
        chk(tag, "cnt_div", int'(cnt_div_o), m_cnt[4]);
        chk(tag, "cnt_fpu", int'(cnt_fpu_o), m_cnt[5]);
        chk(tag, "cnt_exb", int'(cnt_exb_o), m_cnt[6]);
    endtask

    // advance the model by one clock using the driven inputs
    task automatic model_step();
        int hz, ok, stall, halt, jump;
        int n_sl [5];
        hz = int'(hazard_i);
        ok = step_i && (m_st == 1 || m_st == 2);
        q_fetch = 0; q_faddr = 0; q_commit = 0; q_exb = 0;
        foreach (n_sl[i]) n_sl[i] = m_sl[i];
        m_err = (step_i && !ok) ? 1 : 0;
        if (m_st == 0 && load_i) begin
            m_st = 1;
        end else if (ok) begin
            stall = (hz != 0 && m_sl[1] == 2);
            halt  = !stall && m_st == 1 && halt_dec_i && m_sl[1] == 2;
            jump  = !stall && !halt && m_st == 1 && jump_i && m_sl[1] == 2;
            q_commit = (m_sl[4] == 2) && !(term_wb_i && (!fp_empty_i || m_sl[3] == 2));
            m_cnt[0] = bump(m_cnt[0]);
            if (m_sl[4] == 2) m_cnt[1] = bump(m_cnt[1]);
            n_sl[4] = m_sl[3];
            n_sl[3] = m_sl[2];
            if (stall) begin
                m_cnt[hz + 1] = bump(m_cnt[hz + 1]);
                n_sl[2] = (hz == 5) ? 0 : 1;
                q_exb = (hz != 5);
            end else begin
                n_sl[2] = m_sl[1];
                if (m_st == 1 && !halt) begin
                    q_fetch = 1;
                    q_faddr = jump ? int'(jump_tgt_i) : m_pc;
                    n_sl[1] = jump ? 1 : m_sl[0];
                    n_sl[0] = 2;
                end else begin
                    n_sl[1] = 1;
                end
            end
            if (m_st == 2 && fp_empty_i && m_sl[4] != 0 && m_sl[1] != 2
                && m_sl[2] != 2 && m_sl[3] != 2) m_st = 3;
            if (halt) m_st = 2;
            if (q_fetch) begin
                m_ppc = q_faddr;
                m_pc  = (q_faddr + 4) & PMASK;
            end
        end
        foreach (n_sl[i]) m_sl[i] = n_sl[i];
    endtask

    // one clock: drive, check same-cycle strobes, then check registered state
    task automatic cyc(string tag, bit ld, bit st, bit hd, bit jp, int tgt,
                       int hz, bit fpe, bit tw);
        @(negedge clk);
        load_i = ld; step_i = st; halt_dec_i = hd; jump_i = jp;
        jump_tgt_i = PW'(tgt); hazard_i = 3'(hz); fp_empty_i = fpe; term_wb_i = tw;
        #0.5;
        model_step();
        chk(tag, "fetch_en", int'(fetch_en_o), q_fetch);
        if (q_fetch) chk(tag, "fetch_pc", int'(fetch_pc_o), q_faddr);
        chk(tag, "wb_commit", int'(wb_commit_o), q_commit);
        chk(tag, "ex_bubble", int'(ex_bubble_o), q_exb);
        @(posedge clk);
        #0.5;
        cmp_regs(tag);
    endtask

    task automatic stp(string tag);
        cyc(tag, 0, 1, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; load_i = 0; step_i = 0; halt_dec_i = 0; jump_i = 0;
        hazard_i = '0; fp_empty_i = 1; term_wb_i = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        #0.5;
        cmp_regs("R1");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();                                  // R1
        stp("R2");                                   // step while idle is rejected
        cyc("R2", 1, 0, 0, 0, 0, 0, 1, 0);           // load
        cyc("R2", 1, 0, 0, 0, 0, 0, 1, 0);           // load while running ignored
        for (int i = 0; i < 6; i++) stp("R3");       // fill, retire counts R10
        stp("R10");
        cyc("R6", 0, 1, 0, 0, 0, 0, 0, 1);           // terminator, FP busy
        cyc("R6", 0, 1, 0, 0, 0, 0, 1, 1);           // terminator, MEM live
        cyc("R6", 0, 1, 0, 0, 0, 0, 1, 0);
        for (int h = 1; h <= 4; h++) cyc("R8", 0, 1, 0, 0, 0, h, 1, 0);
        cyc("R9", 0, 1, 0, 0, 0, 5, 1, 0);
        stp("R3");
        cyc("R7", 0, 1, 0, 1, 'h0100, 0, 1, 0);      // jump
        cyc("R8", 0, 1, 0, 0, 0, 1, 1, 0);           // hazard with ID bubble ignored
        stp("R3");
        cyc("R7", 0, 1, 0, 1, 'hFFFC, 0, 1, 0);      // jump, address wrap
        stp("R7");
        for (int i = 0; i < 20; i++) stp("R11");
        for (int i = 0; i < 18; i++) cyc("R11", 0, 1, 0, 0, 0, 1, 1, 0);
        cyc("R4", 0, 1, 1, 0, 0, 0, 1, 0);           // halt decode
        for (int i = 0; i < 5; i++) cyc("R5", 0, 1, 0, 0, 0, 0, 0, 0);
        stp("R5");
        stp("R5");
        stp("R2");                                   // halted: rejected
        cyc("R5", 1, 0, 0, 0, 0, 0, 1, 0);           // load in halted ignored
        do_reset();
        cyc("R2", 1, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) stp("R3");
        cyc("R7", 0, 1, 1, 1, 'h0200, 0, 1, 0);      // halt wins over jump
        for (int i = 0; i < 5; i++) stp("R4");
        finish_run();
    end
endmodule